// File: doc/BRIEF.md
# Device Address Translation Cache

This block sits on the DMA side of an endpoint and turns guest page addresses into host addresses before the engine sends memory traffic. A DMA engine presents a lookup (guest address plus a read/write flag). On a hit whose cached permissions allow the access, the block returns the host address marked as translated. When the entry does not allow the access, the block returns the guest address unchanged with the default address type, so the host-side remapper still walks its tables.

On a miss the block sends one translation request for the window that holds the guest page. The window is 4 KB shifted left by a programmed size code. The block collects one completion entry per 4 KB page of that window and fills a slot in an 8-entry fully associative store, replacing slots in round-robin order. A failed completion leaves the store unchanged and reports a fault for that lookup.

The host side can revoke mappings with an invalidation for a range of guest pages. The block drops every overlapping entry at once. It signals completion only after every translated access it has handed out has been retired by the DMA engine.

Top module: `dev_xlat_cache`

## Requirements
- R1: After reset, rspValid, trqValid and invDone are low, and lkReady and invReady are high while no invalidation is offered.
- R2: A lookup that misses while atsEnable is high causes one request on the translation-request port, visible in the cycle after acceptance. The request carries trqAt = 2'b01, trqAddr = the guest address with its low 12+stuCode bits cleared, and trqLen = 2^stuCode. It carries a tag, and trqTag stays stable until trqReady is seen.
- R3: A completion beat with cplStatus = 3'b000 is a success beat. cplPage carries host address bits 63:12, and cplFlags bit 0 = read allowed, bit 1 = write allowed, bit 2 = untranslated-only. After 2^stuCode such beats the entry is written. Its read and write rights are the AND over all beats, and its untranslated-only flag is the OR over all beats. The stalled lookup's response appears in the cycle after the last beat.
- R4: A lookup that hits an entry with the needed right and untranslated-only clear is answered in the cycle after acceptance with rspAt = 2'b10 and the host address (host window base plus guest offset inside the window). No request is issued.
- R5: A hit on an entry whose untranslated-only flag is set, or which lacks the read right (for lkWrite = 0) or the write right (for lkWrite = 1), answers with rspAt = 2'b00 and the original guest address.
- R6: A completion beat with any nonzero cplStatus (3'b001 = unsupported request) creates no entry. The stalled lookup is answered with rspFault = 1, rspAt = 2'b00 and its guest address, and a repeat lookup of that page misses again.
- R7: A completion whose cplTag differs from the outstanding request tag is ignored.
- R8: While atsEnable is low, no request is issued and every lookup is answered in the next cycle with rspAt = 2'b00 and the guest address.
- R9: An entry filled with size code k covers all guest pages of its 4 KB·2^k window. Any address in that window hits and maps to the same offset from the host window base.
- R10: The store has 8 slots filled in round-robin order. After eight fills of distinct pages, a ninth fill evicts the oldest of those eight and keeps the second oldest.
- R11: While a translation is outstanding, a lookup that misses (including one to the pending page) is held off with lkReady low. A lookup that hits another entry is still accepted and answered.
- R12: An accepted invalidation (invPage, invPages pages) removes every entry whose window overlaps pages [invPage, invPage+invPages). Later lookups to those pages miss, and entries outside the range still hit.
- R13: Each translated response counts as one in-flight access, and each accDone pulse retires one. invDone is a one-cycle pulse that comes only once the count is zero. With nothing in flight, it comes two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| atsEnable | input | 1 | Translation use enabled |
| stuCode | input | 3 | Window size code: 4 KB shifted by this value |
| lkValid | input | 1 | Lookup offered |
| lkReady | output | 1 | Lookup accepted this cycle when high with lkValid |
| lkAddr | input | 64 | Guest address of the lookup |
| lkWrite | input | 1 | Lookup is for a write |
| rspValid | output | 1 | Lookup response pulse |
| rspAddr | output | 64 | Address to use for the access |
| rspAt | output | 2 | Address type of the access (00 default, 10 translated) |
| rspFault | output | 1 | Translation failed for this lookup |
| accDone | input | 1 | One translated access has finished |
| trqValid | output | 1 | Translation request pending |
| trqReady | input | 1 | Translation request taken |
| trqAddr | output | 64 | Guest window base |
| trqLen | output | 10 | Window size in 4 KB pages |
| trqAt | output | 2 | Address type of the request (always 01) |
| trqTag | output | 5 | Request tag |
| cplValid | input | 1 | Completion beat present |
| cplTag | input | 5 | Completion tag |
| cplStatus | input | 3 | Completion status (000 success) |
| cplPage | input | 52 | Host page number of this beat |
| cplFlags | input | 3 | Untranslated-only, write, read |
| invValid | input | 1 | Invalidation offered |
| invReady | output | 1 | Invalidation can be taken |
| invPage | input | 52 | First guest page to revoke |
| invPages | input | 16 | Number of pages to revoke |
| invDone | output | 1 | Invalidation complete pulse |

## Verification
The hardest situation to reach from the ports is an invalidation that must wait: translated responses have to be handed out and left unretired, then an invalidation accepted, and invDone must stay low for several cycles until the last accDone arrives. The stimulus reaches it by making one deliberate hit, offering the invalidation with the access still open, and retiring it only after idle cycles. A second hard case is the hit-under-fill path. There the bench holds the completion back after taking the request, offers a lookup to the pending page and then one to a cached page, and checks that only the second is accepted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam logic [1:0] AT_DEF  = 2'b00;
  localparam logic [1:0] AT_REQ  = 2'b01;
  localparam logic [1:0] AT_XLAT = 2'b10;
  localparam logic [2:0] CPL_OK  = 3'b000;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic takeLookup;  // answer the presented lookup now
    logic useCache;    // translation enabled for that answer
    logic capture;     // latch lookup as the pending miss
    logic beat;        // accept a completion beat
    logic firstBeat;   // this beat starts a new window
    logic commit;      // last beat: write entry, answer pending lookup
    logic fail;        // failed completion: answer pending lookup with fault
    logic flush;       // apply invalidation range
  } xlatStrobes_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int STU_W  = 3,
  parameter int TAG_W  = 5,
  parameter int INFL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             atsEnable,
  input  logic [STU_W-1:0] stuCode,
  input  logic             lkValid,
  output logic             lkReady,
  input  logic             hit,
  output logic             trqValid,
  input  logic             trqReady,
  output logic [TAG_W-1:0] trqTag,
  input  logic             cplValid,
  input  logic [TAG_W-1:0] cplTag,
  input  logic [2:0]       cplStatus,
  input  logic             invValid,
  output logic             invReady,
  output logic             invDone,
  input  logic             xlatIssued,
  input  logic             accDone,
  output xlatStrobes_t     st
);
  localparam int BEAT_W = 1 << STU_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DRAIN} state_t;
  state_t state;

  logic [TAG_W-1:0]  tagR;
  logic [BEAT_W-1:0] beatCnt, lastIdx;
  logic [INFL_W-1:0] inflight;
  logic              invDoneR;
  logic              tagMatch;

  assign trqTag  = tagR;
  assign invDone = invDoneR;

  always_comb begin
    st           = '0;
    st.useCache  = atsEnable;
    st.firstBeat = (beatCnt == '0);
    tagMatch     = (state == S_WAIT) && cplValid && (cplTag == tagR);
    invReady     = (state == S_IDLE);
    trqValid     = (state == S_REQ) && atsEnable;
    case (state)
      S_IDLE:  lkReady = !invValid;
      S_REQ:   lkReady = !atsEnable || hit;
      S_WAIT:  lkReady = (!atsEnable || hit) && !cplValid;
      default: lkReady = 1'b0;
    endcase
    if (lkValid && lkReady) begin
      if (state == S_IDLE && atsEnable && !hit) st.capture = 1'b1;
      else                                      st.takeLookup = 1'b1;
    end
    st.flush = invValid && invReady;
    if (tagMatch) begin
      if (cplStatus != CPL_OK) st.fail = 1'b1;
      else begin
        st.beat   = 1'b1;
        st.commit = (beatCnt == lastIdx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tagR     <= '0;
      beatCnt  <= '0;
      lastIdx  <= '0;
      inflight <= '0;
      invDoneR <= 1'b0;
    end else begin
      invDoneR <= 1'b0;
      inflight <= inflight + INFL_W'(xlatIssued) - INFL_W'(accDone);
      case (state)
        S_IDLE: begin
          if (st.flush) state <= S_DRAIN;
          else if (st.capture) begin
            state   <= S_REQ;
            lastIdx <= (BEAT_W'(1) << stuCode) - BEAT_W'(1);
          end
        end
        S_REQ: begin
          if (trqValid && trqReady) begin
            state   <= S_WAIT;
            beatCnt <= '0;
          end
        end
        S_WAIT: begin
          if (st.fail || st.commit) begin
            state <= S_IDLE;
            tagR  <= tagR + TAG_W'(1);
          end else if (st.beat) beatCnt <= beatCnt + BEAT_W'(1);
        end
        default: begin
          if (inflight == '0) begin
            invDoneR <= 1'b1;
            state    <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    invDone |=> !invDone);
  // R13
  done_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    invDone |-> inflight == '0);
  // R13
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> (inflight != '0) || xlatIssued);
  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlatIssued && !accDone) |-> inflight != '1);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trqValid && !trqReady && atsEnable) |=> (trqValid || !atsEnable) && $stable(trqTag));
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int STU_W   = 3,
  parameter int INV_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlatStrobes_t     st,
  input  logic [63:0]      lkAddr,
  input  logic             lkWrite,
  input  logic [STU_W-1:0] stuCode,
  input  logic [51:0]      cplPage,
  input  logic [2:0]       cplFlags,
  input  logic [51:0]      invPage,
  input  logic [INV_W-1:0] invPages,
  output logic             hit,
  output logic [63:0]      trqAddr,
  output logic [9:0]       trqLen,
  output logic             rspValid,
  output logic [63:0]      rspAddr,
  output logic [1:0]       rspAt,
  output logic             rspFault
);
  localparam int PG_W  = 52;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [PG_W-1:0] pgMask(input logic [STU_W-1:0] lg);
    pgMask = {PG_W{1'b1}} << lg;
  endfunction

  function automatic logic overlaps(input logic [PG_W-1:0] eBase, input logic [STU_W-1:0] lg,
                                    input logic [PG_W-1:0] iBase, input logic [INV_W-1:0] n);
    logic [PG_W:0] eLo, eHi, iLo, iHi;
    eLo = {1'b0, eBase};
    eHi = eLo + ((PG_W+1)'(1) << lg);
    iLo = {1'b0, iBase};
    iHi = iLo + (PG_W+1)'(n);
    overlaps = (eLo < iHi) && (iLo < eHi);
  endfunction

  logic [ENTRIES-1:0] vld, rdP, wrP, uoP, ovl;
  logic [PG_W-1:0]    basePg [ENTRIES];
  logic [PG_W-1:0]    hostPg [ENTRIES];
  logic [STU_W-1:0]   lgArr  [ENTRIES];
  logic [IDX_W-1:0]   rrPtr, hitIdx;

  logic [63:0]      pAddr;
  logic             pWrite;
  logic [STU_W-1:0] pLg;
  logic [PG_W-1:0]  accHost;
  logic             accRd, accWr, accUo;

  // lookup match, lowest slot wins
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && vld[i] && (((lkAddr[63:12] ^ basePg[i]) & pgMask(lgArr[i])) == '0)) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  logic [PG_W-1:0] hMask, hitHostPg;
  logic            hitOk;
  assign hMask     = pgMask(lgArr[hitIdx]);
  assign hitHostPg = (hostPg[hitIdx] & hMask) | (lkAddr[63:12] & ~hMask);
  assign hitOk     = (lkWrite ? wrP[hitIdx] : rdP[hitIdx]) && !uoP[hitIdx];

  // running merge of completion beats
  logic [PG_W-1:0] nHost, pMask, pendHostPg;
  logic            nRd, nWr, nUo, pendOk;
  assign nHost      = st.firstBeat ? cplPage : accHost;
  assign nRd        = cplFlags[0] & (st.firstBeat | accRd);
  assign nWr        = cplFlags[1] & (st.firstBeat | accWr);
  assign nUo        = cplFlags[2] | (!st.firstBeat & accUo);
  assign pMask      = pgMask(pLg);
  assign pendHostPg = (nHost & pMask) | (pAddr[63:12] & ~pMask);
  assign pendOk     = (pWrite ? nWr : nRd) && !nUo;

  assign trqAddr = {pAddr[63:12] & pMask, 12'h000};
  assign trqLen  = 10'd1 << pLg;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ovl
    assign ovl[g] = overlaps(basePg[g], lgArr[g], invPage, invPages);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld      <= '0;
      rrPtr    <= '0;
      pAddr    <= '0;
      pWrite   <= 1'b0;
      pLg      <= '0;
      accHost  <= '0;
      accRd    <= 1'b0;
      accWr    <= 1'b0;
      accUo    <= 1'b0;
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspAt    <= AT_DEF;
      rspFault <= 1'b0;
    end else begin
      if (st.flush) vld <= vld & ~ovl;
      if (st.commit) begin
        vld[rrPtr] <= 1'b1;
        rrPtr      <= (rrPtr == IDX_W'(ENTRIES-1)) ? '0 : rrPtr + IDX_W'(1);
      end
      if (st.capture) begin
        pAddr  <= lkAddr;
        pWrite <= lkWrite;
        pLg    <= stuCode;
      end
      if (st.beat) begin
        accHost <= nHost;
        accRd   <= nRd;
        accWr   <= nWr;
        accUo   <= nUo;
      end
      rspValid <= st.takeLookup | st.commit | st.fail;
      rspFault <= 1'b0;
      if (st.takeLookup) begin
        if (st.useCache && hit && hitOk) begin
          rspAt   <= AT_XLAT;
          rspAddr <= {hitHostPg, lkAddr[11:0]};
        end else begin
          rspAt   <= AT_DEF;
          rspAddr <= lkAddr;
        end
      end else if (st.commit) begin
        rspAt   <= pendOk ? AT_XLAT : AT_DEF;
        rspAddr <= pendOk ? {pendHostPg, pAddr[11:0]} : pAddr;
      end else if (st.fail) begin
        rspAt    <= AT_DEF;
        rspAddr  <= pAddr;
        rspFault <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.commit) begin
      basePg[rrPtr] <= pAddr[63:12] & pMask;
      hostPg[rrPtr] <= nHost;
      lgArr[rrPtr]  <= pLg;
      rdP[rrPtr]    <= nRd;
      wrP[rrPtr]    <= nWr;
      uoP[rrPtr]    <= nUo;
    end
  end

  // R6
  fault_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspAt == AT_DEF);
  // R4
  rsp_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAt == AT_DEF) || (rspAt == AT_XLAT));
  // R3
  commit_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> vld != '0);
endmodule

// File: rtl/dev_xlat_cache.sv
module dev_xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int STU_W   = 3,
  parameter int TAG_W   = 5,
  parameter int INFL_W  = 6,
  parameter int INV_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             atsEnable,
  input  logic [STU_W-1:0] stuCode,
  input  logic             lkValid,
  output logic             lkReady,
  input  logic [63:0]      lkAddr,
  input  logic             lkWrite,
  output logic             rspValid,
  output logic [63:0]      rspAddr,
  output logic [1:0]       rspAt,
  output logic             rspFault,
  input  logic             accDone,
  output logic             trqValid,
  input  logic             trqReady,
  output logic [63:0]      trqAddr,
  output logic [9:0]       trqLen,
  output logic [1:0]       trqAt,
  output logic [TAG_W-1:0] trqTag,
  input  logic             cplValid,
  input  logic [TAG_W-1:0] cplTag,
  input  logic [2:0]       cplStatus,
  input  logic [51:0]      cplPage,
  input  logic [2:0]       cplFlags,
  input  logic             invValid,
  output logic             invReady,
  input  logic [51:0]      invPage,
  input  logic [INV_W-1:0] invPages,
  output logic             invDone
);
  xlatStrobes_t st;
  logic hit, xlatIssued;

  assign trqAt      = AT_REQ;
  assign xlatIssued = rspValid && (rspAt == AT_XLAT);

  xlat_ctrl #(.STU_W(STU_W), .TAG_W(TAG_W), .INFL_W(INFL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .atsEnable(atsEnable), .stuCode(stuCode),
    .lkValid(lkValid), .lkReady(lkReady), .hit(hit),
    .trqValid(trqValid), .trqReady(trqReady), .trqTag(trqTag),
    .cplValid(cplValid), .cplTag(cplTag), .cplStatus(cplStatus),
    .invValid(invValid), .invReady(invReady), .invDone(invDone),
    .xlatIssued(xlatIssued), .accDone(accDone), .st(st)
  );

  xlat_store #(.ENTRIES(ENTRIES), .STU_W(STU_W), .INV_W(INV_W)) uStore (
    .clk(clk), .rstN(rstN), .st(st), .lkAddr(lkAddr), .lkWrite(lkWrite),
    .stuCode(stuCode), .cplPage(cplPage), .cplFlags(cplFlags),
    .invPage(invPage), .invPages(invPages), .hit(hit),
    .trqAddr(trqAddr), .trqLen(trqLen), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspAt(rspAt), .rspFault(rspFault)
  );
endmodule

// File: tb/dev_xlat_cache_test.sv
module dev_xlat_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rstN = 0;
  logic atsEnable = 0;
  logic [2:0] stuCode = 0;
  logic lkValid = 0, lkWrite = 0;
  logic [63:0] lkAddr = 0;
  logic lkReady, rspValid, rspFault, accDone = 0;
  logic [63:0] rspAddr, trqAddr;
  logic [1:0] rspAt, trqAt;
  logic trqValid, trqReady = 0;
  logic [9:0] trqLen;
  logic [4:0] trqTag, cplTag = 0;
  logic cplValid = 0;
  logic [2:0] cplStatus = 0, cplFlags = 0;
  logic [51:0] cplPage = 0, invPage = 0;
  logic [15:0] invPages = 0;
  logic invValid = 0, invReady, invDone;

  int nChk = 0, nFail = 0, pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_xlat_cache uut (
    .clk(clk), .rstN(rstN), .atsEnable(atsEnable), .stuCode(stuCode),
    .lkValid(lkValid), .lkReady(lkReady), .lkAddr(lkAddr), .lkWrite(lkWrite),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspAt(rspAt), .rspFault(rspFault),
    .accDone(accDone), .trqValid(trqValid), .trqReady(trqReady), .trqAddr(trqAddr),
    .trqLen(trqLen), .trqAt(trqAt), .trqTag(trqTag), .cplValid(cplValid),
    .cplTag(cplTag), .cplStatus(cplStatus), .cplPage(cplPage), .cplFlags(cplFlags),
    .invValid(invValid), .invReady(invReady), .invPage(invPage),
    .invPages(invPages), .invDone(invDone)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doLookup(input logic [63:0] a, input bit w);
    int n = 0;
    @(negedge clk);
    lkAddr = a; lkWrite = w; lkValid = 1;
    while (!lkReady && n < 50) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    lkValid = 0;
  endtask

  task automatic expectRsp(input logic [1:0] at, input logic [63:0] a, input bit flt, input string req);
    chk(rspValid == 1, {req, " rspValid"}, 64'(rspValid), 64'd1);
    chk(rspAt == at, {req, " rspAt"}, 64'(rspAt), 64'(at));
    chk(rspAddr == a, {req, " rspAddr"}, rspAddr, a);
    chk(rspFault == flt, {req, " rspFault"}, 64'(rspFault), 64'(flt));
    if (rspValid && rspAt == 2'b10) pend++;
  endtask

  task automatic serveReq(input logic [63:0] a, input logic [9:0] len, input string req, output logic [4:0] tag);
    chk(trqValid == 1, {req, " trqValid"}, 64'(trqValid), 64'd1);
    chk(trqAt == 2'b01, {req, " trqAt"}, 64'(trqAt), 64'd1);
    chk(trqAddr == a, {req, " trqAddr"}, trqAddr, a);
    chk(trqLen == len, {req, " trqLen"}, 64'(trqLen), 64'(len));
    tag = trqTag;
    trqReady = 1;
    @(posedge clk);
    @(negedge clk);
    trqReady = 0;
  endtask

  task automatic sendBeat(input logic [4:0] tag, input logic [2:0] sts, input logic [51:0] pg, input logic [2:0] fl);
    @(negedge clk);
    cplValid = 1; cplTag = tag; cplStatus = sts; cplPage = pg; cplFlags = fl;
    @(posedge clk);
    @(negedge clk);
    cplValid = 0;
  endtask

  task automatic fill(input logic [63:0] a, input bit w, input logic [51:0] pg, input logic [2:0] fl);
    logic [4:0] tg;
    doLookup(a, w);
    serveReq({a[63:12], 12'h000}, 10'd1, "R2 fill", tg);
    sendBeat(tg, 3'b000, pg, fl);
  endtask

  task automatic retire();
    while (pend > 0) begin
      @(negedge clk); accDone = 1;
      @(posedge clk);
      @(negedge clk); accDone = 0;
      pend--;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(rspValid == 0, "R1 rspValid", 64'(rspValid), 0);
    chk(trqValid == 0, "R1 trqValid", 64'(trqValid), 0);
    chk(invDone == 0, "R1 invDone", 64'(invDone), 0);
    chk(lkReady == 1, "R1 lkReady", 64'(lkReady), 1);
    chk(invReady == 1, "R1 invReady", 64'(invReady), 1);
  endtask

  task automatic testDisabled();
    atsEnable = 0;
    doLookup(64'h1000_3ABC, 0);
    expectRsp(2'b00, 64'h1000_3ABC, 0, "R8 bypass");
    chk(trqValid == 0, "R8 no request", 64'(trqValid), 0);
    atsEnable = 1;
  endtask

  task automatic testMissHit();
    logic [4:0] tg;
    doLookup(64'h1000_3ABC, 0);
    chk(rspValid == 0, "R2 no early rsp", 64'(rspValid), 0);
    serveReq(64'h1000_3000, 10'd1, "R2 miss", tg);
    sendBeat(tg, 3'b000, 52'h8F3A1, 3'b011);
    expectRsp(2'b10, 64'h8F3A_1ABC, 0, "R3 fill");
    doLookup(64'h1000_3010, 1);
    expectRsp(2'b10, 64'h8F3A_1010, 0, "R4 hit");
    chk(trqValid == 0, "R4 no request", 64'(trqValid), 0);
    retire();
  endtask

  task automatic testPerm();
    fill(64'h1000_5040, 1, 52'h22222, 3'b001);
    expectRsp(2'b00, 64'h1000_5040, 0, "R5 write denied");
    doLookup(64'h1000_5040, 0);
    expectRsp(2'b10, 64'h2222_2040, 0, "R5 read allowed");
    fill(64'h1000_6008, 0, 52'h33333, 3'b111);
    expectRsp(2'b00, 64'h1000_6008, 0, "R5 untranslated-only fill");
    doLookup(64'h1000_6008, 0);
    expectRsp(2'b00, 64'h1000_6008, 0, "R5 untranslated-only hit");
    retire();
  endtask

  task automatic testFail();
    logic [4:0] tg;
    doLookup(64'h1000_7100, 0);
    serveReq(64'h1000_7000, 10'd1, "R6 req", tg);
    sendBeat(tg, 3'b001, 52'h0, 3'b000);
    expectRsp(2'b00, 64'h1000_7100, 1, "R6 fault");
    doLookup(64'h1000_7100, 0);
    chk(trqValid == 1, "R6 no entry made", 64'(trqValid), 1);
    serveReq(64'h1000_7000, 10'd1, "R6 retry", tg);
    sendBeat(tg, 3'b000, 52'h44444, 3'b011);
    expectRsp(2'b10, 64'h4444_4100, 0, "R6 retry fill");
    retire();
  endtask

  task automatic testTag();
    logic [4:0] tg;
    doLookup(64'h1000_8000, 0);
    serveReq(64'h1000_8000, 10'd1, "R7 req", tg);
    sendBeat(tg ^ 5'd1, 3'b000, 52'h12345, 3'b011);
    chk(rspValid == 0, "R7 wrong tag ignored", 64'(rspValid), 0);
    sendBeat(tg, 3'b000, 52'h55555, 3'b001);
    expectRsp(2'b10, 64'h5555_5000, 0, "R7 right tag");
    retire();
  endtask

  task automatic testWindow();
    logic [4:0] tg;
    stuCode = 1;
    doLookup(64'h2000_3234, 0);
    serveReq(64'h2000_2000, 10'd2, "R9 window req", tg);
    sendBeat(tg, 3'b000, 52'h66660, 3'b011);
    chk(rspValid == 0, "R3 waits all beats", 64'(rspValid), 0);
    sendBeat(tg, 3'b000, 52'h66661, 3'b001);
    expectRsp(2'b10, 64'h6666_1234, 0, "R9 upper page");
    doLookup(64'h2000_2010, 0);
    expectRsp(2'b10, 64'h6666_0010, 0, "R9 lower page hit");
    doLookup(64'h2000_2010, 1);
    expectRsp(2'b00, 64'h2000_2010, 0, "R3 write AND over beats");
    stuCode = 0;
    retire();
  endtask

  task automatic testStall();
    logic [4:0] tg;
    doLookup(64'h1000_9000, 0);
    serveReq(64'h1000_9000, 10'd1, "R11 req", tg);
    lkAddr = 64'h1000_9000; lkWrite = 0; lkValid = 1;
    #1;
    chk(lkReady == 0, "R11 pending page held", 64'(lkReady), 0);
    @(negedge clk);
    chk(lkReady == 0, "R11 still held", 64'(lkReady), 0);
    lkAddr = 64'h1000_3004;
    #1;
    chk(lkReady == 1, "R11 other hit accepted", 64'(lkReady), 1);
    @(posedge clk);
    @(negedge clk);
    lkValid = 0;
    expectRsp(2'b10, 64'h8F3A_1004, 0, "R11 hit under fill");
    sendBeat(tg, 3'b000, 52'h77777, 3'b011);
    expectRsp(2'b10, 64'h7777_7000, 0, "R11 fill done");
    retire();
  endtask

  task automatic testRoundRobin();
    logic [4:0] tg;
    for (int k = 0; k < 9; k++) begin
      fill(64'h3000_0000 + 64'(k) * 64'h1000, 0, 52'h90000 + 52'(k), 3'b011);
      expectRsp(2'b10, 64'h9000_0000 + 64'(k) * 64'h1000, 0, "R10 fill");
    end
    doLookup(64'h3000_1000, 0);
    expectRsp(2'b10, 64'h9000_1000, 0, "R10 second oldest kept");
    doLookup(64'h3000_0000, 0);
    chk(trqValid == 1, "R10 oldest evicted", 64'(trqValid), 1);
    serveReq(64'h3000_0000, 10'd1, "R10 refill", tg);
    sendBeat(tg, 3'b000, 52'h90000, 3'b011);
    expectRsp(2'b10, 64'h9000_0000, 0, "R10 refill done");
    retire();
  endtask

  task automatic testInvalidate();
    logic [4:0] tg;
    int seen = 0;
    // nothing in flight: completes two cycles after acceptance
    @(negedge clk);
    invPage = 52'h12345_0000; invPages = 16'd1; invValid = 1;
    chk(invReady == 1, "R13 invReady", 64'(invReady), 1);
    @(posedge clk); @(negedge clk); invValid = 0;
    chk(invDone == 0, "R13 no early done", 64'(invDone), 0);
    @(negedge clk);
    chk(invDone == 1, "R13 idle done", 64'(invDone), 1);
    @(negedge clk);
    chk(invDone == 0, "R13 done pulse", 64'(invDone), 0);
    // one translated access left open
    doLookup(64'h3000_6000, 0);
    expectRsp(2'b10, 64'h9000_6000, 0, "R13 open access");
    @(negedge clk);
    invPage = 52'h30003; invPages = 16'd2; invValid = 1;
    @(posedge clk); @(negedge clk); invValid = 0;
    for (int c = 0; c < 4; c++) begin
      chk(invDone == 0, "R13 waits for access", 64'(invDone), 0);
      @(negedge clk);
    end
    retire();
    for (int c = 0; c < 5; c++) begin
      if (invDone) seen++;
      @(negedge clk);
    end
    chk(seen == 1, "R13 single done after drain", 64'(seen), 1);
    doLookup(64'h3000_6000, 0);
    expectRsp(2'b10, 64'h9000_6000, 0, "R12 outside range kept");
    doLookup(64'h3000_5000, 0);
    expectRsp(2'b10, 64'h9000_5000, 0, "R12 page after range kept");
    retire();
    doLookup(64'h3000_3000, 0);
    chk(trqValid == 1, "R12 first page flushed", 64'(trqValid), 1);
    serveReq(64'h3000_3000, 10'd1, "R12 refill", tg);
    sendBeat(tg, 3'b000, 52'h90003, 3'b011);
    expectRsp(2'b10, 64'h9000_3000, 0, "R12 refill");
    doLookup(64'h3000_4000, 0);
    chk(trqValid == 1, "R12 second page flushed", 64'(trqValid), 1);
    serveReq(64'h3000_4000, 10'd1, "R12 refill2", tg);
    sendBeat(tg, 3'b000, 52'h90004, 3'b011);
    expectRsp(2'b10, 64'h9000_4000, 0, "R12 refill2");
    retire();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testDisabled();
    testMissHit();
    testPerm();
    testFail();
    testTag();
    testWindow();
    testStall();
    testRoundRobin();
    testInvalidate();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule